// File: doc/BRIEF.md
# Device Power State Controller

This controller sits beside one device and keeps track of which of five power states that device is in. The states run from fully active to unpowered. Software asks for a new state through a request port. The controller checks each request against the ordering rules. It then either rejects the request with a one-cycle error pulse, or runs the transition for a programmable number of cycles and signals completion with a one-cycle done pulse. Any request that arrives while a transition is running is dropped without a response.

From the settled state the block drives four outputs:

- whether configuration access is possible,
- whether address decoding is enabled,
- whether the device context is still valid,
- a performance-level index, which only has a meaning while the device is fully active.

Actual rail switching, clock gating and context save/restore are left to other blocks. Those blocks act on these outputs.

Top module: `devpwr_ctrl`

## Requirements
- R1: After reset the state is unpowered (code 4), and the performance index, context-valid, busy, done and error are all 0.
- R2: State codes are 0 active, 1 light, 2 deep, 3 auxiliary-standby and 4 unpowered; a higher code is a deeper state. A request is accepted when its target is deeper than the current state, and acceptance raises busy on the next cycle.
- R3: A target that is shallower but not code 0, a target equal to the current state, and codes 5 to 7 are all illegal. An illegal request raises error for the single following cycle, leaves the state unchanged and does not start a transition. A request for code 0 from any other state is legal.
- R4: A request accepted at edge k with latency L (L = 0 counts as 1) changes the current state at edge k+L. Done is high for exactly the one cycle after that edge, and busy is high from edge k+1 until the state change.
- R5: While busy, request, target and latency inputs are ignored. No error is raised and the pending target is kept.
- R6: Configuration access is enabled in every state except unpowered. Address decoding is enabled only in the active state. Both follow the current state, not the pending target.
- R7: Context-valid clears when a transition into or out of the unpowered state completes. It sets on a reinit acknowledge given while active and idle. Otherwise it holds, so a round trip through light, deep or auxiliary-standby keeps it.
- R8: A performance write given while active and idle loads the written value, limited to PERF_LEVELS-1 (15 by default). Writes in any other state or while busy are ignored. The index returns to 0 when a transition out of the active state completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | State change request strobe |
| req_target | input | 3 | Requested state code |
| req_latency | input | LAT_W | Transition length in cycles (0 means 1) |
| reinit_ack | input | 1 | Software reports the device is reinitialized |
| perf_wr | input | 1 | Performance index write strobe |
| perf_val | input | PERF_W | Performance index write value |
| cur_state | output | 3 | Current settled state code |
| busy | output | 1 | Transition in progress |
| done | output | 1 | One-cycle transition completion pulse |
| err | output | 1 | One-cycle illegal request pulse |
| ctx_valid | output | 1 | Device context is valid |
| cfg_access_en | output | 1 | Configuration access possible |
| mem_decode_en | output | 1 | Address decoding enabled |
| perf_idx | output | PERF_W | Current performance index |

## Verification
A wrong legality decision shows at the ports on the very next cycle: either a busy that should not appear or an error pulse that is missing. A miscounted latency shows as done and the state code arriving one or more cycles away from the expected edge. A lost pending target shows as the wrong state code at completion. Errors in the context or performance flags stay hidden until the matching reinit or write is given, or until a transition completes. For that reason the stimulus mixes those strobes with transitions and with requests made while busy.

// File: rtl/dps_pkg.sv
package dps_pkg;

  typedef enum logic [2:0] {
    PS_ACTIVE    = 3'd0,
    PS_LIGHT     = 3'd1,
    PS_DEEP      = 3'd2,
    PS_AUX       = 3'd3,
    PS_UNPOWERED = 3'd4
  } pwr_state_e;

  localparam logic [2:0] PS_DEEPEST_CODE = 3'd4;

  // Deeper moves always allowed; shallower moves only to the active state.
  function automatic logic move_is_legal(input logic [2:0] from_s, input logic [2:0] to_s);
    if (to_s > PS_DEEPEST_CODE) return 1'b0;
    if (to_s > from_s) return 1'b1;
    if ((to_s == 3'd0) && (from_s != 3'd0)) return 1'b1;
    return 1'b0;
  endfunction

endpackage

// File: rtl/dps_legality.sv
module dps_legality
  import dps_pkg::*;
(
  input  logic       req_valid,
  input  logic       busy,
  input  logic [2:0] cur_code,
  input  logic [2:0] req_target,
  output logic       accept,
  output logic       reject
);

  logic legal;

  always_comb begin
    legal  = move_is_legal(cur_code, req_target);
    accept = req_valid && !busy && legal;
    reject = req_valid && !busy && !legal;
  end

endmodule

// File: rtl/dps_timer.sv
module dps_timer #(
  parameter int LAT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LAT_W-1:0] latency,
  output logic             busy,
  output logic             expire
);

  localparam logic [LAT_W-1:0] ONE = LAT_W'(1);

  logic [LAT_W-1:0] cnt;

  function automatic logic [LAT_W-1:0] eff_latency(input logic [LAT_W-1:0] l);
    return (l == '0) ? ONE : l;
  endfunction

  assign expire = busy && (cnt == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= eff_latency(latency);
    end else if (busy) begin
      if (cnt == ONE) busy <= 1'b0;
      else            cnt  <= cnt - ONE;
    end
  end

  p_start_sets_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

  p_busy_count_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !expire) |=> busy);

endmodule

// File: rtl/dps_perf.sv
module dps_perf #(
  parameter int PERF_W      = 8,
  parameter int PERF_LEVELS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PERF_W-1:0] wr_val,
  input  logic              clear,
  output logic [PERF_W-1:0] perf_idx
);

  localparam logic [PERF_W-1:0] PERF_MAX = PERF_W'(PERF_LEVELS - 1);

  function automatic logic [PERF_W-1:0] clamp_perf(input logic [PERF_W-1:0] v);
    return (v > PERF_MAX) ? PERF_MAX : v;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      perf_idx <= '0;
    else if (clear)  perf_idx <= '0;
    else if (wr_en)  perf_idx <= clamp_perf(wr_val);
  end

  p_perf_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    perf_idx <= PERF_MAX);

endmodule

// File: rtl/devpwr_ctrl.sv
module devpwr_ctrl
  import dps_pkg::*;
#(
  parameter int LAT_W       = 4,
  parameter int PERF_W      = 8,
  parameter int PERF_LEVELS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_target,
  input  logic [LAT_W-1:0]  req_latency,
  input  logic              reinit_ack,
  input  logic              perf_wr,
  input  logic [PERF_W-1:0] perf_val,
  output logic [2:0]        cur_state,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              ctx_valid,
  output logic              cfg_access_en,
  output logic              mem_decode_en,
  output logic [PERF_W-1:0] perf_idx
);

  pwr_state_e state_q;
  pwr_state_e target_q;
  logic       accept;
  logic       reject;
  logic       expire;
  logic       leaving_cold;
  logic       entering_cold;
  logic       leaving_active;
  logic       idle_active;

  assign cur_state      = state_q;
  assign idle_active    = (state_q == PS_ACTIVE) && !busy;
  assign leaving_cold   = expire && (state_q == PS_UNPOWERED);
  assign entering_cold  = expire && (target_q == PS_UNPOWERED);
  assign leaving_active = expire && (state_q == PS_ACTIVE);
  assign cfg_access_en  = (state_q != PS_UNPOWERED);
  assign mem_decode_en  = (state_q == PS_ACTIVE);

  dps_legality u_legal (
    .req_valid  (req_valid),
    .busy       (busy),
    .cur_code   (state_q),
    .req_target (req_target),
    .accept     (accept),
    .reject     (reject)
  );

  dps_timer #(.LAT_W(LAT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (accept),
    .latency (req_latency),
    .busy    (busy),
    .expire  (expire)
  );

  dps_perf #(.PERF_W(PERF_W), .PERF_LEVELS(PERF_LEVELS)) u_perf (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (perf_wr && idle_active),
    .wr_val   (perf_val),
    .clear    (leaving_active),
    .perf_idx (perf_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= PS_UNPOWERED;
      target_q <= PS_UNPOWERED;
      done     <= 1'b0;
      err      <= 1'b0;
    end else begin
      done <= expire;
      err  <= reject;
      if (accept) target_q <= pwr_state_e'(req_target);
      if (expire) state_q  <= target_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              ctx_valid <= 1'b0;
    else if (leaving_cold || entering_cold)  ctx_valid <= 1'b0;
    else if (reinit_ack && idle_active)      ctx_valid <= 1'b1;
  end

  p_reject_holds_state_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> (err && !busy && $stable(cur_state)));

  p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_no_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid) |=> !err);

  p_state_moves_only_on_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_state) |-> done);

  p_cfg_rise_after_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_access_en) |-> $past(busy));

  p_ctx_cleared_cold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    entering_cold |=> !ctx_valid);

  p_perf_zero_outside_active_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_state != 3'd0) |-> (perf_idx == '0));

endmodule

// File: tb/test_devpwr_ctrl.sv
module test_devpwr_ctrl;

  localparam int LAT_W = 4;
  localparam int PERF_W = 8;
  localparam int PERF_LEVELS = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_target = '0;
  logic [LAT_W-1:0] req_latency = '0;
  logic reinit_ack = 1'b0;
  logic perf_wr = 1'b0;
  logic [PERF_W-1:0] perf_val = '0;
  logic [2:0] cur_state;
  logic busy, done, err, ctx_valid, cfg_access_en, mem_decode_en;
  logic [PERF_W-1:0] perf_idx;

  int vectors = 0;
  int fails = 0;
  bit finished = 0;

  // reference model state
  int m_state = 4, m_tgt = 4, m_cnt = 0, m_perf = 0;
  bit m_busy = 0, m_done = 0, m_err = 0, m_ctx = 0;

  always #5 clk = ~clk;

  devpwr_ctrl #(.LAT_W(LAT_W), .PERF_W(PERF_W), .PERF_LEVELS(PERF_LEVELS)) i_devpwr_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_target(req_target),
    .req_latency(req_latency), .reinit_ack(reinit_ack), .perf_wr(perf_wr),
    .perf_val(perf_val), .cur_state(cur_state), .busy(busy), .done(done), .err(err),
    .ctx_valid(ctx_valid), .cfg_access_en(cfg_access_en), .mem_decode_en(mem_decode_en),
    .perf_idx(perf_idx)
  );

  always @(posedge clk) begin
    int old;
    bit legal;
    if (!rst_n) begin
      m_state = 4; m_tgt = 4; m_cnt = 0; m_perf = 0;
      m_busy = 0; m_done = 0; m_err = 0; m_ctx = 0;
    end else begin
      old = m_state;
      m_done = 0;
      m_err = 0;
      if (m_busy) begin
        if (m_cnt == 1) begin
          m_state = m_tgt; m_busy = 0; m_done = 1;
          if (m_tgt == 4 || old == 4) m_ctx = 0;
          if (old == 0) m_perf = 0;
        end else m_cnt = m_cnt - 1;
      end else begin
        if (req_valid) begin
          legal = (req_target <= 4) &&
                  ((int'(req_target) > old) || (req_target == 0 && old != 0));
          if (legal) begin
            m_busy = 1; m_tgt = req_target;
            m_cnt = (req_latency == 0) ? 1 : int'(req_latency);
          end else m_err = 1;
        end
        if (reinit_ack && old == 0) m_ctx = 1;
        if (perf_wr && old == 0) m_perf = (perf_val > PERF_LEVELS - 1) ? PERF_LEVELS - 1 : int'(perf_val);
      end
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      chk("R2 R4 state", cur_state, m_state);
      chk("R4 R5 busy", busy, m_busy);
      chk("R4 done", done, m_done);
      chk("R3 err", err, m_err);
      chk("R7 ctx_valid", ctx_valid, m_ctx);
      chk("R6 cfg_access_en", cfg_access_en, (m_state != 4));
      chk("R6 mem_decode_en", mem_decode_en, (m_state == 0));
      chk("R8 perf_idx", perf_idx, m_perf);
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      req_valid = 0; reinit_ack = 0; perf_wr = 0;
    end
  endtask

  task automatic request(input int tgt, input int lat);
    @(negedge clk); #1;
    req_valid = 1; req_target = 3'(tgt); req_latency = LAT_W'(lat);
    @(negedge clk); #1;
    req_valid = 0;
  endtask

  task automatic pulse_perf(input int v);
    @(negedge clk); #1; perf_wr = 1; perf_val = PERF_W'(v);
    @(negedge clk); #1; perf_wr = 0;
  endtask

  task automatic pulse_reinit();
    @(negedge clk); #1; reinit_ack = 1;
    @(negedge clk); #1; reinit_ack = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1: reset values
    chk("R1 reset state", cur_state, 4);
    chk("R1 reset perf", perf_idx, 0);
    chk("R1 reset ctx", ctx_valid, 0);
    chk("R1 reset busy/done/err", {busy, done, err}, 0);
    #1 rst_n = 1;
    idle(2);
    request(3, 2);     // R3: shallower non-zero from unpowered is rejected
    idle(2);
    request(0, 3);     // legal wake to active
    idle(5);
    pulse_reinit();    // R7 set
    pulse_perf(200);   // R8 clamp to 15
    idle(1);
    pulse_perf(7);
    request(1, 0);     // R2 deeper, latency 0 acts as 1
    pulse_perf(9);     // R8 ignored outside active
    idle(2);
    request(2, 2);
    idle(4);
    request(1, 1);     // R3 shallower non-zero
    request(2, 1);     // R3 same state
    request(6, 1);     // R3 out-of-range code
    idle(2);
    request(3, 6);     // long transition
    request(0, 1);     // R5 ignored while busy
    idle(8);
    request(0, 2);     // back to active, context kept (R7)
    idle(4);
    pulse_perf(5);
    request(4, 3);     // into unpowered clears context
    idle(5);
    request(0, 1);
    idle(3);
    // mixed stimulus phase
    for (int c = 0; c < 1500; c++) begin
      @(negedge clk); #1;
      req_valid   = ($urandom % 10) < 3;
      req_target  = 3'($urandom % 8);
      req_latency = LAT_W'($urandom % 5);
      reinit_ack  = ($urandom % 10) == 0;
      perf_wr     = ($urandom % 5) == 0;
      perf_val    = PERF_W'($urandom % 256);
    end
    idle(10);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule